// File: doc/BRIEF.md
# Multi-Bank Interrupt Winner Selector

This block looks at every interrupt line in one to four banks of 32 lines and picks the single line that should be serviced next for one interrupt class. The class is either the normal class or the fast class. A line can take part only when three things hold: its pending bit is set, its mask bit is clear, and its class bit matches the class requested on `class_sel_i`. Each line has a 5-bit urgency value, and the value 0 is the most urgent.

The block reports two things. The first is a valid flag that is high when at least one line can take part. The second is the global number of the winning line, which is the bank number times 32 plus the bit position. When no line can take part, the number reads zero. The block stores no register state and decodes no bus. The owning controller supplies the state vectors as plain inputs and uses the result when it raises a request to the processor or returns the source code.

The selection is one combinational reduction. Its result is captured in a single output register, so a change on any input shows at the outputs one clock later. The outputs are plain status pins with no handshake. A consumer may read them in any cycle, and they never stall.

Top module: `irq_class_arbiter`

## Requirements
- R1: A line is eligible only when its pending bit is 1, its mask bit is 0, and its class bit equals `class_sel_i` (class bit 1 is the fast class, 0 the normal class). The winner is always an eligible line.
- R2: `win_valid_o` is 1 exactly when at least one line was eligible at the previous rising clock edge.
- R3: Among eligible lines, the one with the numerically smallest urgency value wins. Line n's urgency is `prio_i[5n+4:5n]`.
- R4: When several eligible lines share the smallest urgency value, the one with the highest global line number wins, whether or not the lines are in the same bank.
- R5: The reported number is 32 × bank + bit. Bit position n of `pend_i`, `mask_i` and `cls_i` is global line n.
- R6: When no line is eligible, `win_line_o` is 0 and `win_valid_o` is 0.
- R7: The outputs reflect the inputs sampled at the previous rising edge of `clk`. There is exactly one register of latency.
- R8: While `rst_n` is low, and until the first clock edge after it goes high, `win_valid_o` is 0 and `win_line_o` is 0.
- R9: A masked line, or a line of the other class, has no effect on the outputs even when its urgency value is smaller than that of every eligible line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| class_sel_i | input | 1 | Requested class: 1 = fast, 0 = normal |
| pend_i | input | NUM_BANKS*32 | Pending bit per global line |
| mask_i | input | NUM_BANKS*32 | Mask bit per line, 1 = blocked |
| cls_i | input | NUM_BANKS*32 | Class bit per line, 1 = fast |
| prio_i | input | NUM_BANKS*32*5 | 5-bit urgency per line, 0 = most urgent |
| win_valid_o | output | 1 | At least one line was eligible |
| win_line_o | output | LINE_W | Global number of the winner, 0 when none |

## Verification
Two of the rules can decide the same cycle. The urgency rule and the highest-index tie rule both apply when equal-urgency lines sit in different banks and a more urgent line competes with them. This is provoked in one step: tied lines are placed in banks 0 and 3, and a more urgent line is added in bank 1 that belongs to the other class. While the class selector is low, the bank-3 tie winner must be reported. Once the selector flips, the bank-1 line must be reported, with no cycle of the old answer after the edge. A randomized sweep then compares every result against a plain reference scan written from the requirements.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int LINES_PER_BANK = 32;
  localparam int PRIO_W         = 5;
  localparam int MAX_BANKS      = 4;
endpackage

// File: rtl/irq_pick_tree.sv
// Balanced reduction tree over N candidates (N a power of two).
// At each node the upper-index child wins when its urgency is <= the lower
// child's, which yields "smaller value wins, ties go to the higher index"
// without comparing line numbers.
module irq_pick_tree
  import irq_arb_pkg::*;
#(
  parameter int N      = 32,
  parameter int LINE_W = 7
) (
  input  logic [N-1:0]             leaf_vld,
  input  logic [N-1:0][PRIO_W-1:0] leaf_pri,
  input  logic [N-1:0][LINE_W-1:0] leaf_line,
  output logic                     root_vld,
  output logic [PRIO_W-1:0]        root_pri,
  output logic [LINE_W-1:0]        root_line
);
  localparam int LEVELS = $clog2(N);

  for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
    localparam int W = N >> l;
    logic [W-1:0]             v;
    logic [W-1:0][PRIO_W-1:0] p;
    logic [W-1:0][LINE_W-1:0] ln;

    if (l == 0) begin : g_leaf
      assign v  = leaf_vld;
      assign p  = leaf_pri;
      assign ln = leaf_line;
    end else begin : g_node
      for (genvar k = 0; k < W; k++) begin : g_k
        logic take_hi;
        assign take_hi = g_lvl[l-1].v[2*k+1] &&
                         (!g_lvl[l-1].v[2*k] ||
                          (g_lvl[l-1].p[2*k+1] <= g_lvl[l-1].p[2*k]));
        assign v[k]  = g_lvl[l-1].v[2*k] | g_lvl[l-1].v[2*k+1];
        assign p[k]  = take_hi ? g_lvl[l-1].p[2*k+1]  : g_lvl[l-1].p[2*k];
        assign ln[k] = take_hi ? g_lvl[l-1].ln[2*k+1] : g_lvl[l-1].ln[2*k];
      end
    end
  end

  assign root_vld  = g_lvl[LEVELS].v[0];
  assign root_pri  = g_lvl[LEVELS].p[0];
  assign root_line = g_lvl[LEVELS].ln[0];
endmodule

// File: rtl/irq_bank_pick.sv
// One bank: eligibility filter plus a 32-leaf winner tree.
module irq_bank_pick
  import irq_arb_pkg::*;
#(
  parameter int BANK_IDX = 0,
  parameter int LINE_W   = 7
) (
  input  logic                                  class_sel_i,
  input  logic [LINES_PER_BANK-1:0]             pend_i,
  input  logic [LINES_PER_BANK-1:0]             mask_i,
  input  logic [LINES_PER_BANK-1:0]             cls_i,
  input  logic [LINES_PER_BANK-1:0][PRIO_W-1:0] prio_i,
  output logic                                  hit_o,
  output logic [PRIO_W-1:0]                     pri_o,
  output logic [LINE_W-1:0]                     line_o
);
  logic [LINES_PER_BANK-1:0]             elig;
  logic [LINES_PER_BANK-1:0][LINE_W-1:0] line_no;

  assign elig = pend_i & ~mask_i & ~(cls_i ^ {LINES_PER_BANK{class_sel_i}});

  for (genvar g = 0; g < LINES_PER_BANK; g++) begin : g_num
    assign line_no[g] = LINE_W'(BANK_IDX * LINES_PER_BANK + g);
  end

  irq_pick_tree #(.N(LINES_PER_BANK), .LINE_W(LINE_W)) u_tree (
    .leaf_vld  (elig),
    .leaf_pri  (prio_i),
    .leaf_line (line_no),
    .root_vld  (hit_o),
    .root_pri  (pri_o),
    .root_line (line_o)
  );
endmodule

// File: rtl/irq_class_arbiter.sv
module irq_class_arbiter
  import irq_arb_pkg::*;
#(
  parameter  int NUM_BANKS = 4,
  localparam int LINES     = NUM_BANKS * LINES_PER_BANK,
  localparam int LINE_W    = $clog2(LINES)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     class_sel_i,
  input  logic [LINES-1:0]         pend_i,
  input  logic [LINES-1:0]         mask_i,
  input  logic [LINES-1:0]         cls_i,
  input  logic [LINES*PRIO_W-1:0]  prio_i,
  output logic                     win_valid_o,
  output logic [LINE_W-1:0]        win_line_o
);
  localparam int SLOTS  = 1 << $clog2(NUM_BANKS);
  localparam int BANK_B = LINES_PER_BANK * PRIO_W;

  logic [SLOTS-1:0]             bank_vld;
  logic [SLOTS-1:0][PRIO_W-1:0] bank_pri;
  logic [SLOTS-1:0][LINE_W-1:0] bank_line;

  for (genvar b = 0; b < SLOTS; b++) begin : g_bank
    if (b < NUM_BANKS) begin : g_live
      logic [LINES_PER_BANK-1:0][PRIO_W-1:0] pri_slice;
      assign pri_slice = prio_i[b*BANK_B +: BANK_B];
      irq_bank_pick #(.BANK_IDX(b), .LINE_W(LINE_W)) u_bank (
        .class_sel_i (class_sel_i),
        .pend_i      (pend_i[b*LINES_PER_BANK +: LINES_PER_BANK]),
        .mask_i      (mask_i[b*LINES_PER_BANK +: LINES_PER_BANK]),
        .cls_i       (cls_i[b*LINES_PER_BANK +: LINES_PER_BANK]),
        .prio_i      (pri_slice),
        .hit_o       (bank_vld[b]),
        .pri_o       (bank_pri[b]),
        .line_o      (bank_line[b])
      );
    end else begin : g_pad
      assign bank_vld[b]  = 1'b0;
      assign bank_pri[b]  = '0;
      assign bank_line[b] = '0;
    end
  end

  logic              root_vld;
  logic [PRIO_W-1:0] root_pri_unused;
  logic [LINE_W-1:0] root_line;

  irq_pick_tree #(.N(SLOTS), .LINE_W(LINE_W)) u_cross (
    .leaf_vld  (bank_vld),
    .leaf_pri  (bank_pri),
    .leaf_line (bank_line),
    .root_vld  (root_vld),
    .root_pri  (root_pri_unused),
    .root_line (root_line)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_valid_o <= 1'b0;
      win_line_o  <= '0;
    end else begin
      win_valid_o <= root_vld;
      win_line_o  <= root_vld ? root_line : '0;
    end
  end
endmodule

// File: rtl/irq_class_arbiter_chk.sv
module irq_class_arbiter_chk
  import irq_arb_pkg::*;
#(
  parameter  int NUM_BANKS = 4,
  localparam int LINES     = NUM_BANKS * LINES_PER_BANK,
  localparam int LINE_W    = $clog2(LINES)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    class_sel_i,
  input logic [LINES-1:0]        pend_i,
  input logic [LINES-1:0]        mask_i,
  input logic [LINES-1:0]        cls_i,
  input logic [LINES*PRIO_W-1:0] prio_i,
  input logic                    win_valid_o,
  input logic [LINE_W-1:0]       win_line_o
);
  logic                    primed;
  logic [LINES-1:0]        elig_q;
  logic [LINES*PRIO_W-1:0] prio_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed <= 1'b0;
      elig_q <= '0;
      prio_q <= '0;
    end else begin
      primed <= 1'b1;
      elig_q <= pend_i & ~mask_i & (class_sel_i ? cls_i : ~cls_i);
      prio_q <= prio_i;
    end
  end

  logic              more_urgent;
  logic              higher_tie;
  logic [PRIO_W-1:0] win_pri;

  always_comb begin
    win_pri     = prio_q[int'(win_line_o)*PRIO_W +: PRIO_W];
    more_urgent = 1'b0;
    higher_tie  = 1'b0;
    for (int i = 0; i < LINES; i++) begin
      if (elig_q[i] && prio_q[i*PRIO_W +: PRIO_W] < win_pri) more_urgent = 1'b1;
      if (elig_q[i] && prio_q[i*PRIO_W +: PRIO_W] == win_pri &&
          i > int'(win_line_o)) higher_tie = 1'b1;
    end
  end

  AST_IDLE_LINE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !win_valid_o |-> win_line_o == '0); // R6
  AST_VALID_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    primed |-> win_valid_o == (|elig_q)); // R2
  AST_WINNER_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && win_valid_o) |-> elig_q[win_line_o]); // R1
  AST_NONE_MORE_URGENT: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && win_valid_o) |-> !more_urgent); // R3
  AST_TIE_HIGHEST: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && win_valid_o) |-> !higher_tie); // R4
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !primed |-> !win_valid_o); // R8
endmodule

bind irq_class_arbiter irq_class_arbiter_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (.*);

// File: tb/test_irq_class_arbiter.sv
`timescale 1ns/1ps
module test_irq_class_arbiter;
  localparam int NB    = 4;
  localparam int LINES = NB * 32;
  localparam int LW    = $clog2(LINES);

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               class_sel = 1'b0;
  logic [LINES-1:0]   pend = '0;
  logic [LINES-1:0]   mask = '1;
  logic [LINES-1:0]   cls  = '0;
  logic [LINES*5-1:0] prio = '0;
  logic               win_valid;
  logic [LW-1:0]      win_line;

  int n_checks = 0;
  int n_fails  = 0;

  always #4 clk = ~clk;

  irq_class_arbiter #(.NUM_BANKS(NB)) i_irq_class_arbiter (
    .clk         (clk),
    .rst_n       (rst_n),
    .class_sel_i (class_sel),
    .pend_i      (pend),
    .mask_i      (mask),
    .cls_i       (cls),
    .prio_i      (prio),
    .win_valid_o (win_valid),
    .win_line_o  (win_line)
  );

  task automatic check(string req, logic exp_v, int exp_l);
    n_checks++;
    if (win_valid !== exp_v || int'(win_line) != exp_l) begin
      n_fails++;
      $display("FAIL %s: got valid=%0b line=%0d, expected valid=%0b line=%0d",
               req, win_valid, win_line, exp_v, exp_l);
    end
  endtask

  task automatic clear_all();
    pend = '0; mask = '1; cls = '0; prio = '0; class_sel = 1'b0;
  endtask

  task automatic arm(int line, int p, logic c);
    pend[line] = 1'b1; mask[line] = 1'b0; cls[line] = c;
    prio[line*5 +: 5] = 5'(p);
  endtask

  // one posedge between drive and sample
  task automatic settle();
    @(negedge clk);
  endtask

  function automatic void model(output logic v, output int l);
    int bp = 0;
    v = 1'b0; l = 0;
    for (int i = 0; i < LINES; i++) begin
      if (pend[i] && !mask[i] && (cls[i] == class_sel)) begin
        if (!v || int'(prio[i*5 +: 5]) <= bp) begin
          v = 1'b1; l = i; bp = int'(prio[i*5 +: 5]);
        end
      end
    end
  endfunction

  task automatic t_reset();
    @(negedge clk);
    arm(9, 0, 1'b0);
    check("R8 during reset", 1'b0, 0);
    @(negedge clk);
    check("R8 held in reset", 1'b0, 0);
    clear_all();
    rst_n = 1'b1;
    #1 check("R8 after release before edge", 1'b0, 0);
  endtask

  task automatic t_none();
    @(negedge clk); clear_all();
    pend = '1;
    settle(); check("R6 all masked", 1'b0, 0);
    mask = '0; cls = '1; class_sel = 1'b0;
    settle(); check("R6 all other class", 1'b0, 0);
  endtask

  task automatic t_banks();
    for (int b = 0; b < NB; b++) begin
      @(negedge clk); clear_all();
      arm(b*32 + 7, 3, 1'b0);
      settle(); check("R5 bank line number", 1'b1, b*32 + 7);
    end
    @(negedge clk); clear_all(); arm(127, 31, 1'b0);
    settle(); check("R5 last line", 1'b1, 127);
  endtask

  task automatic t_urgency();
    @(negedge clk); clear_all();
    arm(3, 2, 1'b0); arm(100, 9, 1'b0);
    settle(); check("R3 lower index more urgent", 1'b1, 3);
    @(negedge clk); arm(50, 0, 1'b0);
    settle(); check("R3 zero most urgent", 1'b1, 50);
  endtask

  task automatic t_tie();
    @(negedge clk); clear_all();
    arm(10, 4, 1'b0); arm(40, 4, 1'b0); arm(90, 4, 1'b0);
    settle(); check("R4 tie across banks", 1'b1, 90);
    @(negedge clk); clear_all(); arm(5, 6, 1'b0); arm(6, 6, 1'b0);
    settle(); check("R4 tie within bank", 1'b1, 6);
  endtask

  task automatic t_class();
    @(negedge clk); clear_all();
    arm(20, 0, 1'b1); arm(30, 7, 1'b0);
    settle(); check("R1 normal class", 1'b1, 30);
    @(negedge clk); class_sel = 1'b1;
    settle(); check("R1 fast class", 1'b1, 20);
  endtask

  task automatic t_ignore();
    @(negedge clk); clear_all();
    arm(60, 8, 1'b0); arm(61, 1, 1'b0); mask[61] = 1'b1;
    arm(62, 0, 1'b1);
    settle(); check("R9 masked and other-class urgent lines ignored", 1'b1, 60);
    @(negedge clk); mask[61] = 1'b0;
    settle(); check("R9 unmasked line takes over", 1'b1, 61);
  endtask

  task automatic t_latency();
    @(negedge clk); clear_all(); arm(33, 5, 1'b0);
    settle();
    @(negedge clk); clear_all(); arm(70, 5, 1'b0);
    #1 check("R7 old value before edge", 1'b1, 33);
    settle(); check("R7 new value after one edge", 1'b1, 70);
  endtask

  task automatic t_combined();
    @(negedge clk); clear_all();
    arm(2, 3, 1'b0); arm(100, 3, 1'b0); arm(40, 1, 1'b1);
    settle(); check("R4 tie with other-class urgent line", 1'b1, 100);
    @(negedge clk); class_sel = 1'b1;
    settle(); check("R3 class flip picks urgent line", 1'b1, 40);
  endtask

  task automatic t_random();
    logic ev; int el;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      for (int w = 0; w < LINES; w += 32) begin
        pend[w +: 32] = $urandom();
        mask[w +: 32] = $urandom() | $urandom();
        cls[w +: 32]  = $urandom();
      end
      for (int i = 0; i < LINES; i++) prio[i*5 +: 5] = 5'($urandom_range(0, 3));
      class_sel = 1'($urandom());
      model(ev, el);
      settle(); check("R3 R4 random sweep", ev, el);
    end
  endtask

  initial begin
    #(8 * 200000);
    n_fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    t_reset();
    t_none();
    t_banks();
    t_urgency();
    t_tie();
    t_class();
    t_ignore();
    t_latency();
    t_combined();
    t_random();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule